// File: doc/BRIEF.md
# Deferred Translation-Invalidation Sequencer

This block sits between the execute stage of a hart and its address-translation cache. It takes invalidation requests and fence requests from the pipeline over one valid/ready port. Invalidations go into an in-order queue and are sent to the translation cache back to back, so they never stall the pipeline by themselves. All ordering work is left to the fences. A write fence waits for the store buffer to drain. An implicit-reference fence waits until every earlier invalidation has been acknowledged, and it keeps the page-table walker disabled until then. A full fence does both and then performs its own invalidation.

Each invalidation carries an address, a tag and a kind. The kind is supervisor, virtual-guest or guest-physical. The guest-physical kind uses a virtual-machine identifier as its tag. The other two kinds use an address-space identifier. Toward the cache, a request is handed over on a valid/ready pair, and completion comes back later on a one-cycle done pulse. Completions arrive in issue order.

A parameter selects a simple mode. In simple mode every invalidation acts as a full fence of its own kind, and the two split fences retire at once as no-ops. A write fence, a run of invalidations and then an implicit-reference fence leave the translation cache, the walker and the retire signalling in the same state as one full fence.

Top module: `xinv_seq`

## Requirements
- R1: After reset, req_ready is 1, inv_valid is 0, walker_en is 1 and fence_retire is 0.
- R2: The req_op values are: 0 supervisor, 1 virtual-guest and 2 guest-physical invalidation; 3 write fence; 4, 5 and 6 full fence of the supervisor, virtual-guest and guest-physical kind; 7 implicit-reference fence. An accepted invalidation is queued without any stall. Invalidations are presented on inv_kind/inv_tag/inv_addr in acceptance order, with inv_kind 0 = supervisor, 1 = virtual-guest and 2 = guest-physical.
- R3: A guest-physical invalidation keeps only the low VMID_W bits of its tag, and the bits above them are zero. Supervisor and virtual-guest invalidations keep the low ASID_W bits.
- R4: When the queue holds DEPTH entries, req_ready is 0. No accepted request is lost.
- R5: At most MAX_OUT invalidations are issued and not yet acknowledged. At that limit, inv_valid is 0 even if the queue is not empty.
- R6: A write fence holds req_ready at 0 until store_empty is seen high. fence_retire pulses in that same cycle, and walker_en is not affected.
- R7: An implicit-reference fence drives walker_en to 0 from the edge that accepts it. fence_retire pulses in the first cycle in which the queue is empty and no invalidation is outstanding, and walker_en returns to 1 at the following edge.
- R8: A full fence keeps walker_en at 0. It waits until the stores have drained and every earlier invalidation has been acknowledged. It then issues its own invalidation, and it retires in the cycle after that invalidation's acknowledgement.
- R9: While any fence is pending, req_ready is 0, so a following fence or invalidation is held and cannot reach the cache before the fence retires.
- R10: With SIMPLE=1, a write fence or an implicit-reference fence pulses fence_retire in its acceptance cycle, causes no stall, and leaves walker_en at 1.
- R11: With SIMPLE=1, an invalidation behaves as a full fence of the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Pipeline request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 3 | Operation code (see R2) |
| req_tag | input | TAG_W | Address-space or virtual-machine identifier |
| req_addr | input | ADDR_W | Address to invalidate |
| store_empty | input | 1 | Store buffer holds no earlier stores |
| inv_valid | output | 1 | Invalidation offered to the translation cache |
| inv_ready | input | 1 | Translation cache takes the offered invalidation |
| inv_kind | output | 2 | Kind of the offered invalidation |
| inv_tag | output | TAG_W | Tag of the offered invalidation |
| inv_addr | output | ADDR_W | Address of the offered invalidation |
| inv_done | input | 1 | One acknowledgement, in issue order |
| walker_en | output | 1 | Page-table walks allowed |
| fence_retire | output | 1 | A fence retires this cycle |

## Verification
The bench fills the queue while the cache refuses requests, and then drains it to confirm order, tag trimming and back-pressure. A queue that dropped a request or issued out of order would show the wrong entry at the cache port. With the outstanding limit reached, the bench checks that a fifth entry waits for an acknowledgement, and then that an implicit-reference fence retires only after the last acknowledgement. A fence that retired early would pulse too soon, and a walker released early would show walker_en high while acknowledgements are still owed. For the full fence, store_empty is held low after the invalidation drains, to confirm that the fence's own invalidation waits for the stores. An invalidation is also held behind a write fence, to confirm that it does not slip ahead. The simple-mode instance checks that the split fences retire at once and that a plain invalidation stalls like a full fence.

// File: rtl/xinv_pkg.sv
package xinv_pkg;

  localparam logic [2:0] OP_INV_SUP  = 3'd0;
  localparam logic [2:0] OP_INV_VGU  = 3'd1;
  localparam logic [2:0] OP_INV_GPH  = 3'd2;
  localparam logic [2:0] OP_FENCE_W  = 3'd3;
  localparam logic [2:0] OP_FULL_SUP = 3'd4;
  localparam logic [2:0] OP_FULL_VGU = 3'd5;
  localparam logic [2:0] OP_FULL_GPH = 3'd6;
  localparam logic [2:0] OP_FENCE_IR = 3'd7;

  localparam logic [1:0] KIND_SUP = 2'd0;
  localparam logic [1:0] KIND_VGU = 2'd1;
  localparam logic [1:0] KIND_GPH = 2'd2;

  typedef enum logic [2:0] {
    FS_IDLE, FS_WDRAIN, FS_IRWAIT, FS_FULLDRAIN, FS_FULLOWN
  } fence_st_e;

  function automatic logic op_is_inval(logic [2:0] op);
    return !op[2] && (op != OP_FENCE_W);
  endfunction

  function automatic logic op_is_full(logic [2:0] op);
    return op[2] && (op != OP_FENCE_IR);
  endfunction

  function automatic logic op_is_split(logic [2:0] op);
    return (op == OP_FENCE_W) || (op == OP_FENCE_IR);
  endfunction

  function automatic logic [1:0] op_kind(logic [2:0] op);
    return op[1:0];
  endfunction

  // In simple mode a plain invalidation is promoted to the full fence of its kind
  function automatic logic [2:0] simple_map(logic [2:0] op, logic simple);
    if (simple && op_is_inval(op)) return {1'b1, op[1:0]};
    return op;
  endfunction

endpackage

// File: rtl/xinv_fifo.sv
module xinv_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] next_ptr(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R2

endmodule

// File: rtl/xinv_out_cnt.sv
module xinv_out_cnt #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic done,
  output logic zero,
  output logic at_max
);
  localparam int CW = $clog2(MAX_OUT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else begin
      case ({issue, done})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign zero   = (cnt == '0);
  assign at_max = (cnt == CW'(MAX_OUT));

  AST_DONE_NEEDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !zero); // R5
  AST_OUT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !at_max); // R5

endmodule

// File: rtl/xinv_fence_ctl.sv
module xinv_fence_ctl
  import xinv_pkg::*;
#(
  parameter bit SIMPLE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [2:0] op,
  input  logic       store_empty,
  input  logic       xlat_idle,
  output logic       pend,
  output logic       own_push,
  output logic       retire,
  output logic       walker_en
);
  fence_st_e st, nxt;
  logic retire_wait, noop_acc, walk_block_acc;

  always_comb begin
    nxt         = st;
    retire_wait = 1'b0;
    own_push    = 1'b0;
    case (st)
      FS_IDLE: if (acc) begin
        if (op == OP_FENCE_W && !SIMPLE)       nxt = FS_WDRAIN;
        else if (op == OP_FENCE_IR && !SIMPLE) nxt = FS_IRWAIT;
        else if (op_is_full(op))               nxt = FS_FULLDRAIN;
      end
      FS_WDRAIN: if (store_empty) begin
        retire_wait = 1'b1;
        nxt         = FS_IDLE;
      end
      FS_IRWAIT: if (xlat_idle) begin
        retire_wait = 1'b1;
        nxt         = FS_IDLE;
      end
      FS_FULLDRAIN: if (store_empty && xlat_idle) begin
        own_push = 1'b1;
        nxt      = FS_FULLOWN;
      end
      FS_FULLOWN: if (xlat_idle) begin
        retire_wait = 1'b1;
        nxt         = FS_IDLE;
      end
      default: nxt = FS_IDLE;
    endcase
  end

  assign noop_acc       = acc && SIMPLE && op_is_split(op);
  assign walk_block_acc = acc && (op_is_full(op) || (op == OP_FENCE_IR && !SIMPLE));
  assign retire         = retire_wait || noop_acc;
  assign pend           = (st != FS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      walker_en <= 1'b1;
    end else begin
      st <= nxt;
      if (walk_block_acc)   walker_en <= 1'b0;
      else if (retire_wait) walker_en <= 1'b1;
    end
  end

  AST_WALK_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_IRWAIT || st == FS_FULLDRAIN || st == FS_FULLOWN) |-> !walker_en); // R7
  AST_W_WAITS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_WDRAIN && !store_empty) |=> (st == FS_WDRAIN)); // R6
  AST_OWN_NEEDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FS_FULLOWN) |-> $past(store_empty)); // R8

endmodule

// File: rtl/xinv_seq.sv
module xinv_seq
  import xinv_pkg::*;
#(
  parameter int ADDR_W  = 39,
  parameter int ASID_W  = 16,
  parameter int VMID_W  = 14,
  parameter int DEPTH   = 4,
  parameter int MAX_OUT = 4,
  parameter bit SIMPLE  = 1'b0,
  localparam int TAG_W  = (ASID_W > VMID_W) ? ASID_W : VMID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              store_empty,
  output logic              inv_valid,
  input  logic              inv_ready,
  output logic [1:0]        inv_kind,
  output logic [TAG_W-1:0]  inv_tag,
  output logic [ADDR_W-1:0] inv_addr,
  input  logic              inv_done,
  output logic              walker_en,
  output logic              fence_retire
);
  localparam int ENT_W = 2 + TAG_W + ADDR_W;
  localparam logic [TAG_W-1:0] ONES = '1;

  // Keep only the identifier bits that the kind actually carries
  function automatic logic [TAG_W-1:0] fit_tag(logic [1:0] k, logic [TAG_W-1:0] t);
    logic [TAG_W-1:0] m;
    m = (k == KIND_GPH) ? (ONES >> (TAG_W - VMID_W)) : (ONES >> (TAG_W - ASID_W));
    return t & m;
  endfunction

  logic [2:0]       eff_op;
  logic             req_fire, q_push, q_empty, q_full, issue;
  logic             out_zero, out_at_max, xlat_idle;
  logic             pend, own_push;
  logic [ENT_W-1:0] req_ent, own_ent, push_ent, head_ent;

  assign eff_op    = simple_map(req_op, SIMPLE);
  assign req_ready = !pend && !q_full;
  assign req_fire  = req_valid && req_ready;
  assign req_ent   = {op_kind(eff_op), fit_tag(op_kind(eff_op), req_tag), req_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) own_ent <= '0;
    else if (req_fire && op_is_full(eff_op)) own_ent <= req_ent;
  end

  assign q_push   = (req_fire && op_is_inval(eff_op)) || own_push;
  assign push_ent = own_push ? own_ent : req_ent;

  xinv_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(push_ent),
    .pop(issue), .head(head_ent), .empty(q_empty), .full(q_full)
  );

  assign inv_valid = !q_empty && !out_at_max;
  assign issue     = inv_valid && inv_ready;
  assign {inv_kind, inv_tag, inv_addr} = head_ent;

  xinv_out_cnt #(.MAX_OUT(MAX_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .issue(issue), .done(inv_done),
    .zero(out_zero), .at_max(out_at_max)
  );

  assign xlat_idle = q_empty && out_zero;

  xinv_fence_ctl #(.SIMPLE(SIMPLE)) u_fence (
    .clk(clk), .rst_n(rst_n), .acc(req_fire), .op(eff_op),
    .store_empty(store_empty), .xlat_idle(xlat_idle), .pend(pend),
    .own_push(own_push), .retire(fence_retire), .walker_en(walker_en)
  );

  AST_WALK_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walker_en) |-> xlat_idle); // R7
  AST_OWN_PUSH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    own_push |-> !req_fire); // R9

  generate
    if (TAG_W > VMID_W) begin : g_gph_tag_chk
      AST_GPH_TAG_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_kind == KIND_GPH) |-> (inv_tag[TAG_W-1:VMID_W] == '0)); // R3
    end
  endgenerate

endmodule

// File: tb/xinv_seq_tb.sv
module xinv_seq_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        valid_m, valid_s, done_m, done_s;
  logic [2:0]  op;
  logic [15:0] tag;
  logic [38:0] addr;
  logic        store_empty, inv_ready;

  logic        m_ready, m_inv_valid, m_walk, m_retire;
  logic [1:0]  m_kind;
  logic [15:0] m_tag;
  logic [38:0] m_addr;
  logic        s_ready, s_inv_valid, s_walk, s_retire;
  logic [1:0]  s_kind;
  logic [15:0] s_tag;
  logic [38:0] s_addr;

  xinv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(valid_m), .req_ready(m_ready),
    .req_op(op), .req_tag(tag), .req_addr(addr), .store_empty(store_empty),
    .inv_valid(m_inv_valid), .inv_ready(inv_ready), .inv_kind(m_kind),
    .inv_tag(m_tag), .inv_addr(m_addr), .inv_done(done_m),
    .walker_en(m_walk), .fence_retire(m_retire)
  );

  xinv_seq #(.SIMPLE(1'b1)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .req_valid(valid_s), .req_ready(s_ready),
    .req_op(op), .req_tag(tag), .req_addr(addr), .store_empty(store_empty),
    .inv_valid(s_inv_valid), .inv_ready(inv_ready), .inv_kind(s_kind),
    .inv_tag(s_tag), .inv_addr(s_addr), .inv_done(done_s),
    .walker_en(s_walk), .fence_retire(s_retire)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic acc_retire;

  // op[75:73] tag[72:57] addr[56:18] exp_kind[17:16] exp_tag[15:0]
  localparam logic [75:0] VEC [4] = '{
    {3'd0, 16'hABCD, 39'h00_0000_1000, 2'd0, 16'hABCD},
    {3'd2, 16'hFFFF, 39'h7F_FFFF_F000, 2'd2, 16'h3FFF},
    {3'd1, 16'h1234, 39'h00_0000_2340, 2'd1, 16'h1234},
    {3'd2, 16'h8001, 39'h12_3456_7000, 2'd2, 16'h0001}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input bit sel, input logic [2:0] o, input logic [15:0] t, input logic [38:0] a);
    @(negedge clk);
    op = o; tag = t; addr = a;
    if (sel) valid_s = 1'b1; else valid_m = 1'b1;
    #1;
    while (!(sel ? s_ready : m_ready)) begin
      @(negedge clk); #1;
    end
    acc_retire = sel ? s_retire : m_retire;
    @(negedge clk);
    valid_m = 1'b0; valid_s = 1'b0;
  endtask

  task automatic ack(input bit sel);
    if (sel) done_s = 1'b1; else done_m = 1'b1;
    @(negedge clk);
    done_m = 1'b0; done_s = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_m = 0; valid_s = 0; done_m = 0; done_s = 0;
    op = '0; tag = '0; addr = '0; store_empty = 1'b1; inv_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", 64'(m_ready), 64'd1);
    check("R1 inv_valid", 64'(m_inv_valid), 64'd0);
    check("R1 walker_en", 64'(m_walk), 64'd1);
    check("R1 fence_retire", 64'(m_retire), 64'd0);

    // R2/R3/R4: fill the queue while the cache refuses, then drain in order
    for (int i = 0; i < 4; i++) begin
      send(0, VEC[i][75:73], VEC[i][72:57], VEC[i][56:18]);
      check("R2 no stall on invalidation", 64'(m_retire), 64'd0);
    end
    check("R4 req_ready low when full", 64'(m_ready), 64'd0);
    inv_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R2 inv_valid", 64'(m_inv_valid), 64'd1);
      check("R2 kind order", 64'(m_kind), 64'(VEC[i][17:16]));
      check("R3 tag fit", 64'(m_tag), 64'(VEC[i][15:0]));
      check("R2 addr order", 64'(m_addr), 64'(VEC[i][56:18]));
      @(negedge clk);
    end
    check("R2 queue drained", 64'(m_inv_valid), 64'd0);

    // R5: limit of outstanding invalidations
    send(0, 3'd0, 16'h0009, 39'h99);
    check("R5 held at outstanding limit", 64'(m_inv_valid), 64'd0);
    ack(0);
    check("R5 issued after ack", 64'(m_inv_valid), 64'd1);
    check("R5 tag", 64'(m_tag), 64'h9);
    @(negedge clk);

    // R7/R9: implicit-reference fence with four acknowledgements owed
    send(0, 3'd7, 16'h0, 39'h0);
    check("R7 walker low after accept", 64'(m_walk), 64'd0);
    check("R9 stall while pending", 64'(m_ready), 64'd0);
    check("R7 no early retire", 64'(m_retire), 64'd0);
    for (int i = 0; i < 3; i++) begin
      ack(0);
      check("R7 no retire with acks owed", 64'(m_retire), 64'd0);
      check("R7 walker still low", 64'(m_walk), 64'd0);
    end
    ack(0);
    check("R7 retire after last ack", 64'(m_retire), 64'd1);
    check("R7 walker low in retire cycle", 64'(m_walk), 64'd0);
    @(negedge clk);
    check("R7 walker back high", 64'(m_walk), 64'd1);
    check("R7 ready back", 64'(m_ready), 64'd1);

    // R6/R9: write fence waits for stores; a later invalidation is held
    store_empty = 1'b0;
    send(0, 3'd3, 16'h0, 39'h0);
    op = 3'd1; tag = 16'h0077; addr = 39'h5; valid_m = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check("R9 held behind fence", 64'(m_ready), 64'd0);
      check("R9 no later issue", 64'(m_inv_valid), 64'd0);
      check("R6 no retire before drain", 64'(m_retire), 64'd0);
      check("R6 walker unaffected", 64'(m_walk), 64'd1);
      @(negedge clk);
    end
    store_empty = 1'b1;
    #1;
    check("R6 retire on drain", 64'(m_retire), 64'd1);
    @(negedge clk);
    check("R9 ready after retire", 64'(m_ready), 64'd1);
    @(negedge clk);
    valid_m = 1'b0;
    check("R9 held request issued", 64'(m_inv_valid), 64'd1);
    check("R9 held request tag", 64'(m_tag), 64'h77);
    @(negedge clk);
    ack(0);

    // R8: full fence
    inv_ready = 1'b0; store_empty = 1'b0;
    send(0, 3'd0, 16'h0005, 39'h1);
    send(0, 3'd6, 16'hFFFF, 39'h77);
    check("R8 walker low", 64'(m_walk), 64'd0);
    check("R9 stall in full fence", 64'(m_ready), 64'd0);
    inv_ready = 1'b1;
    check("R8 earlier inval first", 64'(m_tag), 64'h5);
    @(negedge clk);
    ack(0);
    for (int i = 0; i < 2; i++) begin
      check("R8 own inval waits for stores", 64'(m_inv_valid), 64'd0);
      @(negedge clk);
    end
    store_empty = 1'b1;
    @(negedge clk);
    check("R8 own inval issued", 64'(m_inv_valid), 64'd1);
    check("R8 own kind", 64'(m_kind), 64'd2);
    check("R8 own tag", 64'(m_tag), 64'h3FFF);
    check("R8 own addr", 64'(m_addr), 64'h77);
    check("R8 no retire yet", 64'(m_retire), 64'd0);
    @(negedge clk);
    check("R8 no retire before ack", 64'(m_retire), 64'd0);
    ack(0);
    check("R8 retire", 64'(m_retire), 64'd1);
    check("R8 walker low at retire", 64'(m_walk), 64'd0);
    @(negedge clk);
    check("R8 walker high after", 64'(m_walk), 64'd1);

    // R10/R11: simple-mode instance
    send(1, 3'd3, 16'h0, 39'h0);
    check("R10 write fence immediate", 64'(acc_retire), 64'd1);
    check("R10 no stall", 64'(s_ready), 64'd1);
    send(1, 3'd7, 16'h0, 39'h0);
    check("R10 ir fence immediate", 64'(acc_retire), 64'd1);
    check("R10 walker unaffected", 64'(s_walk), 64'd1);
    send(1, 3'd1, 16'h0042, 39'h10);
    check("R11 no immediate retire", 64'(acc_retire), 64'd0);
    check("R11 walker low", 64'(s_walk), 64'd0);
    check("R11 stall", 64'(s_ready), 64'd0);
    @(negedge clk);
    check("R11 inval issued", 64'(s_inv_valid), 64'd1);
    check("R11 kind", 64'(s_kind), 64'd1);
    check("R11 tag", 64'(s_tag), 64'h42);
    @(negedge clk);
    ack(1);
    check("R11 retire after ack", 64'(s_retire), 64'd1);
    @(negedge clk);
    check("R11 walker high", 64'(s_walk), 64'd1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule